// File: doc/BRIEF.md
# Autovector Interrupt Acknowledge Responder

This block sits between the active-low interrupt request of a peripheral and a 68000-style processor bus. It watches the three function code pins, the address strobe and the level field carried on address bits A[3:1]. When the processor runs an interrupt acknowledge cycle for the level the peripheral is wired to, and that peripheral is requesting, the block pulls an active-low valid-peripheral-address line. The processor then knows that no vector will come over the data bus. It performs a pseudo-read on the next bus cycle and forms the vector itself.

The block also decodes the acknowledged level onto eight active-low level-select outputs, one per level. For checking, a helper pair of outputs reports the autovector number and the exception table byte address that belong to the acknowledged level. The bus inputs are captured in one register stage, so every decoded output follows its inputs by one clock. The only exception is the release of valid-peripheral-address, which also follows the live address strobe. The reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `avi_iack_responder`

## Requirements
- R1: While reset is held, and until the first acknowledge is captured, all level-select outputs are high, valid-peripheral-address is high, and the vector number and table address read 0.
- R2: An acknowledge is recognised only when the function code sampled at a clock edge is 3'b111 and the address strobe sampled at that edge is low. Otherwise all eight level-select outputs are high after that edge, whatever the interrupt line does.
- R3: After an edge that captures a recognised acknowledge, exactly one level-select output is low, and its index equals the binary value sampled on A[3:1]. Bit i of the level-select bus belongs to level i.
- R4: Valid-peripheral-address goes low only when all of these hold: the captured cycle is a recognised acknowledge, the captured level equals the parameter CFG_LEVEL (1..7), the interrupt line sampled at the same edge was low, and the address strobe is still low.
- R5: Valid-peripheral-address returns high in the same cycle that the address strobe rises, without waiting for a clock edge.
- R6: For a recognised acknowledge of level L with L from 1 to 7, the vector number output reads 24 + L, giving 25 to 31. Otherwise it reads 0.
- R7: The table address output always equals four times the vector number output, giving 064h for level 1 through 07Ch for level 7.
- R8: An acknowledge of level 0 drives level-select output 0 low. It never produces valid-peripheral-address, and its vector number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_i | input | 3 | Processor function code pins (3'b111 marks an acknowledge) |
| as_n_i | input | 1 | Address strobe, active low |
| lvl_i | input | 3 | Address bits A[3:1], the level being acknowledged |
| irq_n_i | input | 1 | Peripheral interrupt request, active low |
| lvl_sel_n_o | output | 8 | Decoded level selects, active low, bit i for level i |
| vpa_n_o | output | 1 | Valid-peripheral-address, active low, requests an autovector |
| vec_num_o | output | 8 | Autovector number of the acknowledged level, 0 when none |
| vec_addr_o | output | 10 | Exception table byte address for that vector |

## Verification
The assertions check the following on every cycle: at most one level-select output is low; valid-peripheral-address is low only while the strobe is low and the configured level's select is low; the reported vector number stays within 25 to 31 and its table address is four times it; and all selects are high after an edge that did not capture an acknowledge. Only the bench's scenarios can show that the selected index and the vector number match the level actually driven on A[3:1]. The same holds for the interrupt line gating the handshake: the bench sweeps every function code and level with the interrupt line both asserted and idle. It also shows the release of valid-peripheral-address in the very cycle the strobe rises.

// File: rtl/avi_pkg.sv
package avi_pkg;

  localparam int FC_W      = 3;
  localparam int LVL_W     = 3;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int VEC_BASE  = 24;
  localparam int ADDR_SHIFT = 2;

  localparam logic [FC_W-1:0] FC_IACK = '1;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] lvl;
    logic             irq;
  } iack_cap_t;

endpackage

// File: rtl/avi_rst_sync.sv
module avi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/avi_cycle_detect.sv
module avi_cycle_detect
  import avi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FC_W-1:0]  fc_i,
  input  logic             as_n_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             irq_n_i,
  output iack_cap_t        cap_o
);

  iack_cap_t cap_d;
  iack_cap_t cap_q;
  logic      cap_en;

  always_comb begin
    cap_en    = 1'b1;
    cap_d.hit = (fc_i == FC_IACK) && !as_n_i;
    cap_d.lvl = cap_d.hit ? lvl_i : '0;
    cap_d.irq = !irq_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  assign cap_o = cap_q;

endmodule

// File: rtl/avi_level_decode.sv
module avi_level_decode
  import avi_pkg::*;
(
  input  logic               hit_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [NUM_LVL-1:0] sel_n_o
);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_sel
    assign sel_n_o[g] = !(hit_i && (lvl_i == LVL_W'(g)));
  end

endmodule

// File: rtl/avi_vector_calc.sv
module avi_vector_calc
  import avi_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              hit_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic valid;

  always_comb begin
    valid  = hit_i && (lvl_i != '0);
    vec_o  = valid ? (VEC_W'(VEC_BASE) + VEC_W'(lvl_i)) : '0;
    addr_o = ADDR_W'(vec_o) << ADDR_SHIFT;
  end

endmodule

// File: rtl/avi_iack_responder.sv
module avi_iack_responder
  import avi_pkg::*;
#(
  parameter int CFG_LEVEL = 6,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FC_W-1:0]    fc_i,
  input  logic               as_n_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               irq_n_i,
  output logic [NUM_LVL-1:0] lvl_sel_n_o,
  output logic               vpa_n_o,
  output logic [VEC_W-1:0]   vec_num_o,
  output logic [ADDR_W-1:0]  vec_addr_o
);

  localparam bit CFG_OK  = (CFG_LEVEL >= 1) && (CFG_LEVEL < NUM_LVL);
  localparam int CFG_IDX = CFG_OK ? CFG_LEVEL : 0;

  logic      rst_sync_n;
  iack_cap_t cap;
  logic      own_sel;

  avi_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  avi_cycle_detect det_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fc_i    (fc_i),
    .as_n_i  (as_n_i),
    .lvl_i   (lvl_i),
    .irq_n_i (irq_n_i),
    .cap_o   (cap)
  );

  avi_level_decode dec_i (
    .hit_i   (cap.hit),
    .lvl_i   (cap.lvl),
    .sel_n_o (lvl_sel_n_o)
  );

  avi_vector_calc #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) vec_i (
    .hit_i  (cap.hit),
    .lvl_i  (cap.lvl),
    .vec_o  (vec_num_o),
    .addr_o (vec_addr_o)
  );

  assign own_sel = CFG_OK && !lvl_sel_n_o[CFG_IDX];
  assign vpa_n_o = !(own_sel && cap.irq && !as_n_i);

endmodule

// File: rtl/avi_iack_chk.sv
module avi_iack_chk
  import avi_pkg::*;
#(
  parameter int CFG_LEVEL = 6,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FC_W-1:0]    fc_i,
  input logic               as_n_i,
  input logic [NUM_LVL-1:0] lvl_sel_n_o,
  input logic               vpa_n_o,
  input logic [VEC_W-1:0]   vec_num_o,
  input logic [ADDR_W-1:0]  vec_addr_o
);

  localparam int CFG_IDX = ((CFG_LEVEL >= 1) && (CFG_LEVEL < NUM_LVL)) ? CFG_LEVEL : 0;

  logic past_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R2
  no_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && (($past(fc_i) != FC_IACK) || $past(as_n_i))) |-> (&lvl_sel_n_o));

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lvl_sel_n_o));

  // R4
  vpa_own_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpa_n_o |-> !lvl_sel_n_o[CFG_IDX]);

  // R5
  vpa_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n_i |-> vpa_n_o);

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_num_o != '0) |-> ((vec_num_o >= VEC_W'(VEC_BASE + 1)) && (vec_num_o <= VEC_W'(VEC_BASE + NUM_LVL - 1))));

  // R7
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr_o == (ADDR_W'(vec_num_o) * ADDR_W'(4)));

endmodule

bind avi_iack_responder avi_iack_chk #(
  .CFG_LEVEL (CFG_LEVEL),
  .VEC_W     (VEC_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .fc_i        (fc_i),
  .as_n_i      (as_n_i),
  .lvl_sel_n_o (lvl_sel_n_o),
  .vpa_n_o     (vpa_n_o),
  .vec_num_o   (vec_num_o),
  .vec_addr_o  (vec_addr_o)
);

// File: tb/avi_iack_responder_tb_top.sv
module avi_iack_responder_tb_top;

  localparam int CFG = 6;

  logic       clk;
  logic       rst_n;
  logic [2:0] fc;
  logic       as_n;
  logic [2:0] lvl;
  logic       irq_n;
  logic [7:0] sel_n;
  logic       vpa_n;
  logic [7:0] vec;
  logic [9:0] addr;

  int checks;
  int fails;
  bit done;

  // behavioural reference: values seen at the last rising edge
  int m_fc, m_as, m_lvl, m_irq;

  avi_iack_responder #(.CFG_LEVEL(CFG)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fc_i        (fc),
    .as_n_i      (as_n),
    .lvl_i       (lvl),
    .irq_n_i     (irq_n),
    .lvl_sel_n_o (sel_n),
    .vpa_n_o     (vpa_n),
    .vec_num_o   (vec),
    .vec_addr_o  (addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    m_fc  = fc;
    m_as  = as_n;
    m_lvl = lvl;
    m_irq = irq_n;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit ack;
    int e_sel, e_vpa, e_vec;
    ack   = (m_fc == 7) && (m_as == 0);
    e_sel = ack ? (8'hFF & ~(1 << m_lvl)) : 8'hFF;
    e_vpa = (ack && m_lvl == CFG && m_irq == 0 && as_n == 1'b0) ? 0 : 1;
    e_vec = (ack && m_lvl >= 1) ? 24 + m_lvl : 0;
    chk(ack ? "R3" : "R2", {tag, " level selects"}, int'(sel_n), e_sel);
    chk((ack && m_lvl == 0) ? "R8" : "R4", {tag, " vpa"}, int'(vpa_n), e_vpa);
    chk("R6", {tag, " vector"}, int'(vec), e_vec);
    chk("R7", {tag, " table address"}, int'(addr), e_vec * 4);
  endtask

  task automatic apply(input int f, input int a, input int l, input int q);
    @(negedge clk);
    fc = 3'(f); as_n = 1'(a); lvl = 3'(l); irq_n = 1'(q);
    @(negedge clk);
    compare("sweep");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    m_fc = 0; m_as = 1; m_lvl = 0; m_irq = 1;
    fc = 3'd0; as_n = 1'b1; lvl = 3'd0; irq_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset selects", int'(sel_n), 8'hFF);
    chk("R1", "reset vpa", int'(vpa_n), 1);
    chk("R1", "reset vector", int'(vec), 0);
    chk("R1", "reset address", int'(addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 idle after reset");

    for (int q = 0; q < 2; q++)
      for (int f = 0; f < 8; f++)
        for (int l = 0; l < 8; l++)
          for (int a = 0; a < 2; a++)
            apply(f, a, l, q);

    // R5: strobe rise releases vpa without a clock edge
    apply(7, 0, CFG, 0);
    chk("R5", "vpa during own ack", int'(vpa_n), 0);
    as_n = 1'b1;
    #1;
    chk("R5", "vpa at strobe release", int'(vpa_n), 1);
    @(negedge clk);
    compare("R5 after release");

    // R8: level 0 acknowledge with request pending
    apply(7, 0, 0, 0);
    chk("R8", "level 0 select", int'(sel_n), 8'hFE);
    chk("R8", "level 0 vpa", int'(vpa_n), 1);

    // R6/R7 corner levels 1 and 7
    apply(7, 0, 1, 1);
    chk("R7", "level 1 address", int'(addr), 'h064);
    apply(7, 0, 7, 1);
    chk("R6", "level 7 vector", int'(vec), 31);
    chk("R7", "level 7 address", int'(addr), 'h07C);

    apply(0, 1, 0, 1);
    finish_run();
  end

endmodule